// File: doc/BRIEF.md
# Secondary-Drive Detection Monitor

This block lives in the primary drive of a two-drive cable. After a power-on reset or a host reset pulse, it watches the shared active-low presence line for a fixed number of millisecond ticks. If the line is asserted in that span, the block records that a secondary drive exists. If the span ends with no assertion, it records that no secondary drive exists. The decision is then frozen until the next reset. It selects whether the primary may light the activity LED through the presence line, and how a diagnostics session ends.

A diagnostics session starts at every reset and at every execute-diagnostics strobe. With a secondary present, the block waits for the active-low diagnostics line to become asserted, which means the secondary passed and is ready to post status. The wait is bounded by a millisecond window. If the window expires, the block raises a timeout flag and posts status anyway. With no secondary, the block posts status as soon as its own diagnostics finish. In the same cycle it asks for the secondary's status register to be cleared to 00h. Both lines pass through a synchronizer and a stability filter before any of this logic sees them.

Top module: `sec_drive_monitor`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, all six outputs are 0.
- R2: If the filtered presence line (active low, 0 = asserted) is asserted before DETECT_MS ticks have counted since reset, sec_present_o becomes 1.
- R3: If DETECT_MS ticks pass with no filtered presence assertion, led_en_o becomes 1 and sec_present_o stays 0. led_en_o is 0 while the decision is open and whenever a secondary is present.
- R4: Once made, the presence decision does not change on later presence-line activity. Only rst_ni or hard_rst_i can change it.
- R5: A line level is accepted only after it has held for STABLE_CYC consecutive synchronized cycles. Shorter pulses have no effect.
- R6: With no secondary, status_ready_o pulses for one cycle once own_diag_done_i is 1, and clr_sec_status_o pulses in that same cycle.
- R7: With a secondary present, sec_passed_o is set when the filtered diagnostics line (active low) goes from negated to asserted after the session started. status_ready_o then pulses without clr_sec_status_o.
- R8: With a secondary present, if DIAG_WAIT_MS ticks elapse in a session without a diagnostics assertion, sec_timeout_o becomes 1 and status_ready_o pulses.
- R9: exec_diag_i starts a new session: it clears sec_passed_o and sec_timeout_o and restarts the wait window.
- R10: status_ready_o never pulses while own_diag_done_i is 0. A pending post is made once it rises.
- R11: A hard_rst_i pulse reopens the presence decision: sec_present_o and led_en_o return to 0 and detection restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| hard_rst_i | input | 1 | One-cycle host reset pulse, restarts detection and session |
| exec_diag_i | input | 1 | One-cycle execute-diagnostics strobe |
| own_diag_done_i | input | 1 | Primary's own diagnostics finished |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| presence_n_i | input | 1 | Sampled presence line, active low |
| diag_n_i | input | 1 | Sampled diagnostics line, active low |
| sec_present_o | output | 1 | Secondary drive detected |
| sec_passed_o | output | 1 | Secondary passed diagnostics in this session |
| sec_timeout_o | output | 1 | Diagnostics wait window expired |
| status_ready_o | output | 1 | One-cycle pulse: post status now |
| clr_sec_status_o | output | 1 | One-cycle pulse: clear secondary status register to 00h |
| led_en_o | output | 1 | Primary may drive the presence line for the activity LED |

## Verification
A line change applied before clock edge k reaches the filtered level at edge k+1+STABLE_CYC. The presence flag and sec_passed_o update one edge later, and status_ready_o one edge after that. With STABLE_CYC=4 the bench therefore waits at least 12 cycles after each line change before it samples. Window results are checked on both sides of the expiry, with a margin of at least one tick period. Expected status posts are queued before the stimulus that causes them. A monitor compares every status_ready_o pulse at the falling edge against the head of the queue. A pulse with nothing queued counts as a failure, and the queue must be empty at the end.

// File: rtl/smon_pkg.sv
package smon_pkg;
  typedef enum logic [1:0] {
    DET_OPEN    = 2'd0,
    DET_PRESENT = 2'd1,
    DET_ABSENT  = 2'd2
  } det_state_e;
endpackage

// File: rtl/smon_line_filter.sv
module smon_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic filt_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] STB_LAST = CW'(STABLE_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   filt_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (synced == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == STB_LAST) begin
      filt_q <= synced;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R5
  filt_follows_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> $past(synced) == filt_q);
endmodule

// File: rtl/smon_presence_det.sv
module smon_presence_det
  import smon_pkg::*;
#(
  parameter int DETECT_MS = 450
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic       pres_asserted_i,
  output det_state_e state_o
);
  localparam int W = $clog2(DETECT_MS + 1);
  localparam logic [W-1:0] LAST = W'(DETECT_MS - 1);

  det_state_e    state_q;
  logic [W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DET_OPEN;
      cnt_q   <= '0;
    end else if (restart_i) begin
      state_q <= DET_OPEN;
      cnt_q   <= '0;
    end else if (state_q == DET_OPEN) begin
      if (pres_asserted_i)  state_q <= DET_PRESENT;
      else if (tick_i) begin
        if (cnt_q == LAST) state_q <= DET_ABSENT;
        else               cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;

  // R4
  decision_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != DET_OPEN && !restart_i) |=> $stable(state_q));
  // R11
  restart_reopens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> state_q == DET_OPEN);
endmodule

// File: rtl/smon_diag_tracker.sv
module smon_diag_tracker #(
  parameter int DIAG_WAIT_MS = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic decided_i,
  input  logic present_i,
  input  logic diag_fall_i,
  input  logic tick_i,
  input  logic own_done_i,
  output logic passed_o,
  output logic timeout_o,
  output logic status_o,
  output logic clr_o
);
  localparam int W = $clog2(DIAG_WAIT_MS + 1);
  localparam logic [W-1:0] LAST = W'(DIAG_WAIT_MS - 1);

  logic         pending_q, passed_q, timeout_q, status_q, clr_q;
  logic [W-1:0] cnt_q;
  logic         waiting, can_post;

  assign waiting  = pending_q && decided_i && present_i && !passed_q && !timeout_q;
  assign can_post = pending_q && decided_i && own_done_i &&
                    (!present_i || passed_q || timeout_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b1;
      passed_q  <= 1'b0;
      timeout_q <= 1'b0;
      status_q  <= 1'b0;
      clr_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      status_q <= 1'b0;
      clr_q    <= 1'b0;
      if (start_i) begin
        pending_q <= 1'b1;
        passed_q  <= 1'b0;
        timeout_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        if (diag_fall_i) passed_q <= 1'b1;
        if (waiting && tick_i) begin
          if (cnt_q == LAST) timeout_q <= 1'b1;
          else               cnt_q     <= cnt_q + 1'b1;
        end
        if (can_post) begin
          status_q  <= 1'b1;
          clr_q     <= !present_i;
          pending_q <= 1'b0;
        end
      end
    end
  end

  assign passed_o  = passed_q;
  assign timeout_o = timeout_q;
  assign status_o  = status_q;
  assign clr_o     = clr_q;

  // R6
  clr_with_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> status_q);
  // R10
  post_needs_own_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q |-> $past(own_done_i));
  // R9
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !passed_q && !timeout_q);
endmodule

// File: rtl/sec_drive_monitor.sv
module sec_drive_monitor
  import smon_pkg::*;
#(
  parameter int DETECT_MS    = 450,
  parameter int DIAG_WAIT_MS = 5000,
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_CYC   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic exec_diag_i,
  input  logic own_diag_done_i,
  input  logic ms_tick_i,
  input  logic presence_n_i,
  input  logic diag_n_i,
  output logic sec_present_o,
  output logic sec_passed_o,
  output logic sec_timeout_o,
  output logic status_ready_o,
  output logic clr_sec_status_o,
  output logic led_en_o
);
  logic       pres_filt, diag_filt, diag_prev_q, diag_fall;
  det_state_e det_state;

  smon_line_filter #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)) u_pres_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(presence_n_i), .filt_o(pres_filt));

  smon_line_filter #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)) u_diag_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(diag_n_i), .filt_o(diag_filt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) diag_prev_q <= 1'b1;
    else         diag_prev_q <= diag_filt;
  end

  assign diag_fall = diag_prev_q && !diag_filt;

  smon_presence_det #(.DETECT_MS(DETECT_MS)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(hard_rst_i), .tick_i(ms_tick_i),
    .pres_asserted_i(!pres_filt), .state_o(det_state));

  smon_diag_tracker #(.DIAG_WAIT_MS(DIAG_WAIT_MS)) u_diag (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(hard_rst_i || exec_diag_i),
    .decided_i(det_state != DET_OPEN),
    .present_i(det_state == DET_PRESENT),
    .diag_fall_i(diag_fall), .tick_i(ms_tick_i), .own_done_i(own_diag_done_i),
    .passed_o(sec_passed_o), .timeout_o(sec_timeout_o),
    .status_o(status_ready_o), .clr_o(clr_sec_status_o));

  assign sec_present_o = (det_state == DET_PRESENT);
  assign led_en_o      = (det_state == DET_ABSENT);

  // R3
  led_excludes_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_en_o |-> !sec_present_o);
  // R8
  timeout_only_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_timeout_o |-> sec_present_o);
  // R7
  present_post_reason_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_ready_o && sec_present_o) |-> (sec_passed_o || sec_timeout_o) && !clr_sec_status_o);
endmodule

// File: tb/sec_drive_monitor_tb.sv
module sec_drive_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DET_MS     = 20;
  localparam int WAIT_MS    = 50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hard_rst = 1'b0, exec_diag = 1'b0, own_done = 1'b0, tick = 1'b0;
  logic pres_n = 1'b1, diag_n = 1'b1;
  logic present, passed, timeout, status, clr, led;

  int n_tests = 0, n_fail = 0, n_posts = 0;
  bit finished = 1'b0;
  logic [3:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_drive_monitor #(.DETECT_MS(DET_MS), .DIAG_WAIT_MS(WAIT_MS),
                      .SYNC_STAGES(2), .STABLE_CYC(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hard_rst_i(hard_rst), .exec_diag_i(exec_diag),
    .own_diag_done_i(own_done), .ms_tick_i(tick), .presence_n_i(pres_n),
    .diag_n_i(diag_n), .sec_present_o(present), .sec_passed_o(passed),
    .sec_timeout_o(timeout), .status_ready_o(status), .clr_sec_status_o(clr),
    .led_en_o(led));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic c, logic p, logic ps, logic t);
    exp_q.push_back({c, p, ps, t});
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  // 1 ms tick every 4 clocks
  initial forever begin
    cyc(3); tick = 1'b1; @(negedge clk); tick = 1'b0;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_ni && status) begin
      n_posts++;
      if (exp_q.size() == 0) check("R10 unexpected post", 1, 0);
      else check("R6/R7/R8 post {clr,present,passed,timeout}",
                 {28'd0, clr, present, passed, timeout}, {28'd0, exp_q.pop_front()});
    end
  end

  initial begin
    cyc(200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seen;
    cyc(5);
    check("R1 reset outputs", {26'd0, present, passed, timeout, status, clr, led}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 first cycle", {26'd0, present, passed, timeout, status, clr, led}, 0);

    // R5: short glitch on presence ignored
    cyc(5); pres_n = 1'b0; cyc(2); pres_n = 1'b1; cyc(20);
    check("R5 glitch ignored", present, 0);
    check("R3 undecided led off", led, 0);

    // R3: window expires, absent
    cyc(100);
    check("R3 led on", led, 1);
    check("R3 not present", present, 0);
    check("R10 no post while own not done", n_posts, 0);
    push(1, 0, 0, 0);
    own_done = 1'b1; cyc(5);
    check("R6 post with clear", n_posts, 1);

    // R4: later activity does not change absent decision
    pres_n = 1'b0; cyc(20);
    check("R4 absent held", present, 0);
    check("R4 led held", led, 1);
    pres_n = 1'b1; cyc(12);

    // R11, R2: host reset reopens, secondary appears
    pulse(hard_rst); cyc(1);
    check("R11 present cleared", present, 0);
    check("R11 led cleared", led, 0);
    cyc(30); pres_n = 1'b0; cyc(12);
    check("R2 present", present, 1);
    check("R3 led off when present", led, 0);
    push(0, 1, 1, 0);
    seen = n_posts;
    diag_n = 1'b0; cyc(14);
    check("R7 passed", passed, 1);
    check("R7 posted", n_posts, seen + 1);
    pres_n = 1'b1; cyc(200);
    check("R4 present held", present, 1);

    // R8, R9: exec with no assertion -> timeout
    diag_n = 1'b1; cyc(12);
    pulse(exec_diag); cyc(1);
    check("R9 passed cleared", passed, 0);
    push(0, 1, 0, 1);
    seen = n_posts;
    cyc(160);
    check("R8 no early timeout", timeout, 0);
    cyc(60);
    check("R8 timeout", timeout, 1);
    check("R8 posted", n_posts, seen + 1);

    // R9, R10: new session, own diagnostics held off
    own_done = 1'b0;
    pulse(exec_diag); cyc(1);
    check("R9 timeout cleared", timeout, 0);
    cyc(20); diag_n = 1'b0; cyc(14);
    check("R7 passed again", passed, 1);
    seen = n_posts;
    check("R10 held off", n_posts, seen);
    push(0, 1, 1, 0);
    own_done = 1'b1; cyc(5);
    check("R10 posted after own done", n_posts, seen + 1);
    check("R9 no late timeout", timeout, 0);

    cyc(10);
    check("queue drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule